// File: doc/BRIEF.md
# Funnel Double Shift Unit

This unit performs a 64-bit shift in either direction in which the vacated bit positions are not cleared. They are loaded from a separate fill operand. The bits pushed out of the word are not lost either. They come back as a second 64-bit result, and a flag reports whether any of them were set. Chaining these operations word by word gives shifts of integers many words long: the spill word of one step becomes the fill word of the next.

The unit takes one operation per cycle and registers its results, so they appear on the cycle after the inputs are sampled. A direction select chooses left or right. When an optional record bit is set, a 4-bit sign/zero/overflow condition value is also updated from the result. When the record bit is clear, that condition value is left untouched.

Top module: `dshift_unit`

## Requirements
- R1: Only the low 6 bits of `amtIn` form the shift count n (0 to 63). Bits 63:6 have no effect on any output.
- R2: Left shift (`opRight`=0): `primaryOut` is `dataIn` shifted left by n, and its low n bits are the low n bits of `fillIn`.
- R3: Left shift: `spillOut` is the top n bits of `dataIn`, right-aligned (`dataIn` >> (64−n)). It is zero for n=0.
- R4: Right shift (`opRight`=1): `primaryOut` is `dataIn` shifted right by n, and its top n bits are the top n bits of `fillIn`.
- R5: Right shift: `spillOut` is the low n bits of `dataIn`, placed in the top n positions (`dataIn` << (64−n)). It is zero for n=0.
- R6: `ovfOut` is 1 exactly when `spillOut` is nonzero.
- R7: With n=0, `primaryOut` equals `dataIn` in both directions.
- R8: `condOut` is written only by an accepted operation whose `recordEn` is 1, and `condValid` pulses for that operation's result cycle. In every other cycle `condOut` keeps its value.
- R9: `condOut` bit 3 is set when `primaryOut` is negative as a signed number, bit 2 when it is positive, bit 1 when it is zero, and bit 0 copies the overflow flag of the same result.
- R10: Results appear one clock after an operation is sampled with `inValid`=1, and `outValid` is high in that cycle. While `inValid` is 0, `primaryOut`, `spillOut` and `ovfOut` hold.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| opRight | input | 1 | 0 selects left shift, 1 selects right shift |
| recordEn | input | 1 | Request a condition update |
| dataIn | input | 64 | Word being shifted |
| amtIn | input | 64 | Shift count source (low 6 bits used) |
| fillIn | input | 64 | Source of the bits entering vacated positions |
| outValid | output | 1 | Result registers updated this cycle |
| primaryOut | output | 64 | Shifted word with fill bits merged |
| spillOut | output | 64 | Bits shifted out of the word |
| ovfOut | output | 1 | Spill word is nonzero |
| condValid | output | 1 | Condition value updated this cycle |
| condOut | output | 4 | Negative, positive, zero, overflow |

## Verification
A behavioural model that builds a 128-bit value and shifts it is run on a table of operand sets. The table has alternating-bit and all-ones data, which show whether fill bits and data bits are confused at the seam. It has counts of 0, 1, 32 and 63, which cover the ends of the mask. It has shift operands with high garbage bits, which show whether those bits leak into the count. Hand-worked directed cases check exact fill placement against a fill word whose top and bottom differ, so a fill taken from the wrong end shows up. Further cases track the condition value across record and non-record operations and across idle cycles.

// File: rtl/dshift_pkg.sv
package dshift_pkg;
  localparam int unsigned DATA_W = 64;
  localparam int unsigned AMT_W  = $clog2(DATA_W);
  localparam int unsigned COND_W = 4;

  localparam int unsigned COND_NEG = 3;
  localparam int unsigned COND_POS = 2;
  localparam int unsigned COND_ZER = 1;
  localparam int unsigned COND_OVF = 0;

  typedef struct packed {
    logic load;
    logic dirRight;
    logic loadCond;
  } dsStrobe_t;
endpackage

// File: rtl/dshift_rotmask.sv
module dshift_rotmask
  import dshift_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W,
  localparam int unsigned SHW = $clog2(WIDTH)
) (
  input  logic             dirRight,
  input  logic [SHW-1:0]   amt,
  input  logic [WIDTH-1:0] data,
  input  logic [WIDTH-1:0] fill,
  output logic [WIDTH-1:0] primary,
  output logic [WIDTH-1:0] spill
);
  localparam logic [SHW:0] WIDTH_X = (SHW+1)'(WIDTH);

  logic [SHW-1:0]     rotAmt;
  logic [2*WIDTH-1:0] doubled;
  logic [WIDTH-1:0]   rotated;
  logic [WIDTH-1:0]   fillSel;
  logic [SHW:0]       amtX;

  assign amtX = {1'b0, amt};
  // right shift by n == left rotate by WIDTH-n (mod WIDTH)
  assign rotAmt  = dirRight ? SHW'(WIDTH_X - amtX) : amt;
  assign doubled = {data, data} << rotAmt;
  assign rotated = doubled[2*WIDTH-1:WIDTH];

  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    localparam logic [SHW:0] I_X = (SHW+1)'(i);
    assign fillSel[i] = dirRight ? ((I_X + amtX) >= WIDTH_X) : (I_X < amtX);
  end

  assign primary = (rotated & ~fillSel) | (fill & fillSel);
  assign spill   = rotated & fillSel;
endmodule

// File: rtl/dshift_ctrl.sv
module dshift_ctrl
  import dshift_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      inValid,
  input  logic      opRight,
  input  logic      recordEn,
  output dsStrobe_t strobe,
  output logic      outValid,
  output logic      condValid
);
  always_comb begin
    strobe.load     = inValid;
    strobe.dirRight = opRight;
    strobe.loadCond = inValid & recordEn;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      condValid <= 1'b0;
    end else begin
      outValid  <= strobe.load;
      condValid <= strobe.loadCond;
    end
  end

  assert_cond_implies_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    condValid |-> outValid);
  assert_valid_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
endmodule

// File: rtl/dshift_datapath.sv
module dshift_datapath
  import dshift_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W,
  localparam int unsigned SHW = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dsStrobe_t         strobe,
  input  logic [WIDTH-1:0]  data,
  input  logic [SHW-1:0]    amt,
  input  logic [WIDTH-1:0]  fill,
  output logic [WIDTH-1:0]  primaryOut,
  output logic [WIDTH-1:0]  spillOut,
  output logic              ovfOut,
  output logic [COND_W-1:0] condOut
);
  logic [WIDTH-1:0]  primaryNext;
  logic [WIDTH-1:0]  spillNext;
  logic              ovfNext;
  logic [COND_W-1:0] condNext;

  dshift_rotmask #(.WIDTH(WIDTH)) u_rotmask (
    .dirRight(strobe.dirRight),
    .amt     (amt),
    .data    (data),
    .fill    (fill),
    .primary (primaryNext),
    .spill   (spillNext)
  );

  assign ovfNext = |spillNext;

  always_comb begin
    condNext           = '0;
    condNext[COND_NEG] = primaryNext[WIDTH-1];
    condNext[COND_ZER] = ~|primaryNext;
    condNext[COND_POS] = ~primaryNext[WIDTH-1] & (|primaryNext);
    condNext[COND_OVF] = ovfNext;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primaryOut <= '0;
      spillOut   <= '0;
      ovfOut     <= 1'b0;
      condOut    <= '0;
    end else begin
      if (strobe.load) begin
        primaryOut <= primaryNext;
        spillOut   <= spillNext;
        ovfOut     <= ovfNext;
      end
      if (strobe.loadCond) condOut <= condNext;
    end
  end

  assert_ovf_tracks_spill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovfOut == (spillOut != '0));
  assert_zero_amt_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.load && amt == '0) |=> (primaryOut == $past(data) && spillOut == '0));
  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.load |=> ($stable(primaryOut) && $stable(spillOut) && $stable(ovfOut)));
  assert_cond_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadCond |=> $stable(condOut));
  assert_cond_encoding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.loadCond |=> (condOut[COND_NEG] == primaryOut[WIDTH-1]
                         && condOut[COND_ZER] == (primaryOut == '0)
                         && condOut[COND_OVF] == ovfOut
                         && $onehot(condOut[COND_NEG:COND_ZER])));
endmodule

// File: rtl/dshift_unit.sv
module dshift_unit
  import dshift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              opRight,
  input  logic              recordEn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] amtIn,
  input  logic [DATA_W-1:0] fillIn,
  output logic              outValid,
  output logic [DATA_W-1:0] primaryOut,
  output logic [DATA_W-1:0] spillOut,
  output logic              ovfOut,
  output logic              condValid,
  output logic [COND_W-1:0] condOut
);
  dsStrobe_t strobe;

  dshift_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .opRight  (opRight),
    .recordEn (recordEn),
    .strobe   (strobe),
    .outValid (outValid),
    .condValid(condValid)
  );

  dshift_datapath #(.WIDTH(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .data      (dataIn),
    .amt       (amtIn[AMT_W-1:0]),
    .fill      (fillIn),
    .primaryOut(primaryOut),
    .spillOut  (spillOut),
    .ovfOut    (ovfOut),
    .condOut   (condOut)
  );
endmodule

// File: tb/dshift_unit_test.sv
module dshift_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic        opRight = 1'b0;
  logic        recordEn = 1'b0;
  logic [63:0] dataIn = '0;
  logic [63:0] amtIn = '0;
  logic [63:0] fillIn = '0;
  logic        outValid;
  logic [63:0] primaryOut;
  logic [63:0] spillOut;
  logic        ovfOut;
  logic        condValid;
  logic [3:0]  condOut;

  int total = 0;
  int failed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dshift_unit uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opRight(opRight),
    .recordEn(recordEn), .dataIn(dataIn), .amtIn(amtIn), .fillIn(fillIn),
    .outValid(outValid), .primaryOut(primaryOut), .spillOut(spillOut),
    .ovfOut(ovfOut), .condValid(condValid), .condOut(condOut)
  );

  typedef struct packed {
    logic        right;
    logic [63:0] data;
    logic [63:0] amt;
    logic [63:0] fill;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 64'd0,                  64'h5555_5555_5555_5555},
    '{1'b1, 64'hAAAA_AAAA_AAAA_AAAA, 64'd0,                  64'h5555_5555_5555_5555},
    '{1'b0, 64'hAAAA_AAAA_AAAA_AAAA, 64'd1,                  64'h5555_5555_5555_5555},
    '{1'b1, 64'hAAAA_AAAA_AAAA_AAAA, 64'd1,                  64'h5555_5555_5555_5555},
    '{1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd32,                 64'h0},
    '{1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'd32,                 64'h0},
    '{1'b0, 64'h0123_4567_89AB_CDEF, 64'd63,                 64'hFEDC_BA98_7654_3210},
    '{1'b1, 64'h0123_4567_89AB_CDEF, 64'd63,                 64'hFEDC_BA98_7654_3210},
    '{1'b0, 64'h8000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFC4, 64'h0F0F_0F0F_0F0F_0F0F},
    '{1'b1, 64'h8000_0000_0000_0001, 64'hDEAD_BEEF_0000_0047, 64'h0F0F_0F0F_0F0F_0F0F},
    '{1'b0, 64'h0000_0000_0000_0000, 64'd17,                 64'hFFFF_FFFF_FFFF_FFFF},
    '{1'b1, 64'h00FF_00FF_00FF_00FF, 64'd9,                  64'h0}
  };

  // Behavioural model: 128-bit shift, fill merged from the requirement text.
  function automatic logic [127:0] model(input logic right, input logic [63:0] d,
                                         input logic [63:0] a, input logic [63:0] f);
    logic [5:0]   n;
    logic [127:0] wide;
    logic [63:0]  lowMask;
    logic [63:0]  p;
    logic [63:0]  s;
    n = a[5:0];                                     // R1
    lowMask = ~(64'hFFFF_FFFF_FFFF_FFFF << n);
    if (!right) begin
      wide = {64'h0, d} << n;
      s = wide[127:64];                             // R3
      p = wide[63:0] | (f & lowMask);               // R2
    end else begin
      wide = {d, 64'h0} >> n;
      p = wide[127:64] | (f & ~(64'hFFFF_FFFF_FFFF_FFFF >> n)); // R4
      s = wide[63:0];                               // R5
    end
    return {s, p};
  endfunction

  function automatic logic [3:0] condOf(input logic [63:0] p, input logic [63:0] s);
    return {p[63], (!p[63] && p != 0), (p == 0), (s != 0)};  // R9
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  // drive at negedge, result sampled at the following negedge
  task automatic runOp(input logic right, input logic rec, input logic [63:0] d,
                       input logic [63:0] a, input logic [63:0] f);
    @(negedge clk);
    inValid = 1'b1; opRight = right; recordEn = rec;
    dataIn = d; amtIn = a; fillIn = f;
    @(negedge clk);
    inValid = 1'b0; recordEn = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [127:0] e;
    logic [3:0]   keptCond;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 primary", primaryOut, 64'h0);
    check("R11 spill", spillOut, 64'h0);
    check("R11 flags", {59'h0, outValid, ovfOut, condValid, 2'b00}, 64'h0);
    check("R11 cond", {60'h0, condOut}, 64'h0);
    rst_n = 1'b1;

    // table walk: R2 R3 R4 R5 R6 R7 R1 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      runOp(VECS[i].right, 1'b1, VECS[i].data, VECS[i].amt, VECS[i].fill);
      e = model(VECS[i].right, VECS[i].data, VECS[i].amt, VECS[i].fill);
      check(VECS[i].right ? "R4 primary" : "R2 primary", primaryOut, e[63:0]);
      check(VECS[i].right ? "R5 spill" : "R3 spill", spillOut, e[127:64]);
      check("R6 overflow", {63'h0, ovfOut}, {63'h0, e[127:64] != 0});
      check("R10 outValid", {63'h0, outValid}, 64'h1);
      check("R9 cond", {60'h0, condOut}, {60'h0, condOf(e[63:0], e[127:64])});
      check("R8 condValid", {63'h0, condValid}, 64'h1);
    end

    // R2 R3 hand case: left 4, low 4 bits from low fill bits
    runOp(1'b0, 1'b0, 64'hF000_0000_0000_0001, 64'd4, 64'hB000_0000_0000_000A);
    check("R2 left fill", primaryOut, 64'h0000_0000_0000_001A);
    check("R3 left spill", spillOut, 64'h0000_0000_0000_000F);
    // R4 R5 hand case: right 8, top byte from top fill byte
    runOp(1'b1, 1'b0, 64'h0000_0000_0000_12AB, 64'd8, 64'hCD00_0000_0000_00EE);
    check("R4 right fill", primaryOut, 64'hCD00_0000_0000_0012);
    check("R5 right spill", spillOut, 64'hAB00_0000_0000_0000);
    // R7 n=0 both directions, garbage upper amount bits (R1)
    runOp(1'b1, 1'b0, 64'h1357_9BDF_2468_ACE0, 64'hFFFF_FFFF_FFFF_FFC0, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R7 right n0 primary", primaryOut, 64'h1357_9BDF_2468_ACE0);
    check("R7 right n0 spill", spillOut, 64'h0);
    runOp(1'b0, 1'b0, 64'h1357_9BDF_2468_ACE0, 64'h40, 64'hFFFF_FFFF_FFFF_FFFF);
    check("R7 left n0 primary", primaryOut, 64'h1357_9BDF_2468_ACE0);
    check("R6 n0 no overflow", {63'h0, ovfOut}, 64'h0);

    // R8: record op sets negative cond, non-record op must not touch it
    runOp(1'b0, 1'b1, 64'h4000_0000_0000_0000, 64'd1, 64'h0);
    check("R9 negative cond", {60'h0, condOut}, 64'h8);
    keptCond = condOut;
    runOp(1'b0, 1'b0, 64'h0, 64'd5, 64'h0);
    check("R8 cond kept", {60'h0, condOut}, {60'h0, keptCond});
    check("R8 no condValid", {63'h0, condValid}, 64'h0);
    check("R8 result still updated", primaryOut, 64'h0);
    // R9 zero with overflow
    runOp(1'b0, 1'b1, 64'h8000_0000_0000_0000, 64'd1, 64'h0);
    check("R9 zero+ovf cond", {60'h0, condOut}, 64'h3);

    // R10 hold while idle
    runOp(1'b1, 1'b0, 64'hFFFF_0000_FFFF_0000, 64'd16, 64'h1234_0000_0000_0000);
    @(negedge clk);
    dataIn = 64'h0; amtIn = 64'd3; fillIn = 64'h0;
    @(negedge clk);
    check("R10 hold primary", primaryOut, 64'h1234_FFFF_0000_FFFF);
    check("R10 hold spill", spillOut, 64'h0);
    check("R10 outValid low", {63'h0, outValid}, 64'h0);

    finishRun();
  end
endmodule